// File: doc/BRIEF.md
# Successive-Approximation Conversion and Power-Down Sequencer

This block is the digital control core of an 8-bit successive-approximation converter. It watches a single convert-start level. A rising edge while the converter is asleep wakes it and starts an internal power-up interval. A falling edge ends tracking and starts a conversion. The conversion is a series of bit trials, most significant bit first, that are checked against an external comparator. A start that comes before power-up or acquisition has finished is remembered and carried out as soon as the interval ends.

At the end of each conversion the block samples the convert-start level. A high level keeps the converter powered, so it returns to tracking for the next sample. A low level sends it back to sleep. The finished code and a one-cycle latch strobe go to a serial port, which is outside this block, as are the comparator and the DAC. All intervals are counted in cycles of the internal clock and set by parameters.

Top module: `sar_seq_core`

## Requirements
- R1: After reset, `powered`, `busy` and `result_valid` are 0 and `result` is 0. The block stays asleep until `conv_start` rises.
- R2: A rising edge of `conv_start` while asleep makes `powered` 1 from the next cycle. A conversion cannot begin until PWRUP_CYC cycles after that edge.
- R3: A falling edge of `conv_start` while tracking, with the acquisition interval over, raises `busy` on the next cycle. `busy` then stays high for exactly BITS*TRIAL_CYC cycles.
- R4: If `conv_start` falls during power-up, the conversion starts by itself when power-up ends. `busy` is first seen PWRUP_CYC+1 sampling points after the rise is driven.
- R5: Trials run from the MSB down. On the first busy cycle `trial_code` is 8'h80. Each trial lasts TRIAL_CYC cycles, and its bit is cleared when `cmp_above` (1 means the trial code is above the input) is high on the trial's last cycle.
- R6: `result` is straight binary: the largest code that does not exceed the input. It appears together with a single-cycle `result_valid` on the first cycle after `busy` falls.
- R7: The `conv_start` level at the end of conversion decides the next state. If it is high, `powered` stays 1 and tracking resumes. If it is low, `powered` drops to 0.
- R8: After a conversion that stays powered, a falling edge within ACQ_CYC cycles is held. The next conversion starts ACQ_CYC cycles after the end of the previous one.
- R9: Edges on `conv_start` while `busy` is high neither lengthen nor restart the conversion, and no extra conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low reset (supply applied) |
| conv_start | input | 1 | Convert-start level, synchronous to clk |
| cmp_above | input | 1 | Comparator: trial code is above the held input |
| trial_code | output | BITS | Code driven to the DAC for the current trial |
| busy | output | 1 | High from hold until the result latch |
| powered | output | 1 | Converter is awake (power-up, tracking or converting) |
| result | output | BITS | Last finished conversion code |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The hardest case to reach is a start that arrives while a timing interval is still open. This happens in two ways: a fall of `conv_start` inside power-up, and a fall inside the acquisition window right after a conversion that stayed powered. The stimulus times the fall of `conv_start` at chosen sampling points after the wake-up edge and after the result strobe. It then counts the sampling points until `busy` appears. A cycle-level behavioural model that tracks earliest-start cycle numbers is compared against the outputs on every clock. This model also covers edges injected in the middle of a conversion.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  typedef enum logic [1:0] {PH_OFF, PH_WAKE, PH_TRACK, PH_CONV} phase_t;

  // Total clock cycles a conversion keeps busy high.
  function automatic int conv_cycles(input int bits, input int per_trial);
    return bits * per_trial;
  endfunction
endpackage

// File: rtl/sarseq_edge.sv
module sarseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic level_q;

  // The level is taken as low when the supply comes up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;
endmodule

// File: rtl/sarseq_gap_timer.sv
module sarseq_gap_timer #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          open_o
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - GW'(1);
  end

  assign open_o = (cnt == '0);

  // R8: a running window shrinks by exactly one each cycle.
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - GW'(1)));
endmodule

// File: rtl/sarseq_bit_engine.sv
module sarseq_bit_engine #(
  parameter int BITS      = 8,
  parameter int TRIAL_CYC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cmp_above,
  output logic [BITS-1:0] trial_code,
  output logic            done,
  output logic [BITS-1:0] final_code
);
  localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int TW = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
  localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

  // Drop the trial bit when the comparator says the trial overshoots.
  function automatic logic [BITS-1:0] settle_bit(input logic [BITS-1:0] code,
                                                 input logic [IW-1:0]   idx,
                                                 input logic            above);
    logic [BITS-1:0] r;
    r = code;
    if (above) r[idx] = 1'b0;
    return r;
  endfunction

  logic          active;
  logic [IW-1:0] idx;
  logic [TW-1:0] tcnt;
  logic          trial_end;
  logic [BITS-1:0] kept;

  assign trial_end  = active && (tcnt == TW'(TRIAL_CYC - 1));
  assign kept       = settle_bit(trial_code, idx, cmp_above);
  assign done       = trial_end && (idx == '0);
  assign final_code = kept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      idx        <= '0;
      tcnt       <= '0;
      trial_code <= '0;
    end else if (start) begin
      active     <= 1'b1;
      idx        <= IW'(BITS - 1);
      tcnt       <= '0;
      trial_code <= MSB_ONLY;
    end else if (active) begin
      if (trial_end) begin
        tcnt <= '0;
        if (idx == '0) begin
          trial_code <= kept;
          active     <= 1'b0;
        end else begin
          trial_code <= kept | (BITS'(1) << (idx - IW'(1)));
          idx        <= idx - IW'(1);
        end
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  // R5: every conversion opens with only the MSB set.
  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (trial_code == MSB_ONLY));
  // R5: bits above the current trial never change inside a trial.
  p_upper_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !trial_end) |=> $stable(trial_code));
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core
  import sarseq_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int TRIAL_CYC = 5,
  parameter int PWRUP_CYC = 10,
  parameter int ACQ_CYC   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conv_start,
  input  logic            cmp_above,
  output logic [BITS-1:0] trial_code,
  output logic            busy,
  output logic            powered,
  output logic [BITS-1:0] result,
  output logic            result_valid
);
  localparam int GAP_MAX  = (PWRUP_CYC > ACQ_CYC) ? PWRUP_CYC : ACQ_CYC;
  localparam int GW       = $clog2(GAP_MAX + 1);
  localparam int CONV_CYC = conv_cycles(BITS, TRIAL_CYC);
  localparam int RW       = $clog2(CONV_CYC + 1) + 1;

  phase_t          phase;
  logic            pend;
  logic            cs_rise, cs_fall;
  logic            gap_open, gap_load;
  logic [GW-1:0]   gap_val;
  logic            eng_start, eng_done;
  logic [BITS-1:0] eng_code;

  sarseq_edge i_edge (
    .clk(clk), .rst_n(rst_n), .level(conv_start), .rise(cs_rise), .fall(cs_fall)
  );

  sarseq_gap_timer #(.GW(GW)) i_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .open_o(gap_open)
  );

  sarseq_bit_engine #(.BITS(BITS), .TRIAL_CYC(TRIAL_CYC)) i_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .cmp_above(cmp_above),
    .trial_code(trial_code), .done(eng_done), .final_code(eng_code)
  );

  // A remembered or fresh start goes ahead only once the window is open.
  always_comb begin
    eng_start = (phase == PH_WAKE || phase == PH_TRACK) && gap_open && (pend || cs_fall);
    gap_load  = 1'b0;
    gap_val   = '0;
    if (phase == PH_OFF && cs_rise) begin
      gap_load = 1'b1;
      gap_val  = GW'(PWRUP_CYC - 1);
    end else if (phase == PH_CONV && eng_done && conv_start) begin
      gap_load = 1'b1;
      gap_val  = GW'(ACQ_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_OFF;
      pend         <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      unique case (phase)
        PH_OFF: begin
          if (cs_rise) begin
            phase <= PH_WAKE;
            pend  <= 1'b0;
          end
        end
        PH_WAKE, PH_TRACK: begin
          if (eng_start) begin
            phase <= PH_CONV;
            pend  <= 1'b0;
          end else begin
            if (cs_fall) pend <= 1'b1;
            if (phase == PH_WAKE && gap_open) phase <= PH_TRACK;
          end
        end
        PH_CONV: begin
          if (eng_done) begin
            result       <= eng_code;
            result_valid <= 1'b1;
            pend         <= 1'b0;
            phase        <= conv_start ? PH_TRACK : PH_OFF;
          end
        end
        default: phase <= PH_OFF;
      endcase
    end
  end

  assign busy    = (phase == PH_CONV);
  assign powered = (phase != PH_OFF);

  // Length of the current busy run, used only by the checks below.
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + RW'(1);
    else           run_len <= '0;
  end

  p_busy_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> powered);
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == RW'(CONV_CYC)));
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  p_stay_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && $past(conv_start)) |-> powered);
  p_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !$past(conv_start)) |-> !powered);
endmodule

// File: tb/test_sar_seq_core.sv
module test_sar_seq_core;
  localparam int BITS      = 8;
  localparam int TRIAL_CYC = 5;
  localparam int PWRUP_CYC = 10;
  localparam int ACQ_CYC   = 2;
  localparam int CONV      = BITS * TRIAL_CYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start = 1'b0;
  logic [7:0] vin_bits = 8'h00;
  logic cmp_above;
  logic [BITS-1:0] trial_code, result;
  logic busy, powered, result_valid;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // Ideal comparator and DAC: the trial is above the held input.
  assign cmp_above = (trial_code > vin_bits);

  sar_seq_core #(.BITS(BITS), .TRIAL_CYC(TRIAL_CYC), .PWRUP_CYC(PWRUP_CYC),
                 .ACQ_CYC(ACQ_CYC)) i_sar_seq_core (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cmp_above(cmp_above),
    .trial_code(trial_code), .busy(busy), .powered(powered),
    .result(result), .result_valid(result_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: phases and earliest-start cycle numbers.
  int m_cyc, m_gate, m_end, m_ph, m_res, m_held, m_start;
  bit m_pend, m_prev, m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pend = 0; m_prev = 0; m_valid = 0; m_res = 0;
      m_cyc = 0; m_gate = 0; m_end = 0; m_held = 0; m_start = -1;
    end else begin
      bit r, f;
      r = conv_start && !m_prev;
      f = !conv_start && m_prev;
      m_cyc++;
      m_valid = 0;
      if (m_ph == 0) begin
        if (r) begin m_ph = 1; m_pend = 0; m_gate = m_cyc + PWRUP_CYC; end
      end else if (m_ph == 3) begin
        if (m_cyc == m_end) begin
          m_valid = 1; m_res = m_held; m_pend = 0;
          if (conv_start) begin m_ph = 2; m_gate = m_cyc + ACQ_CYC; end
          else m_ph = 0;
        end
      end else begin
        if (m_cyc >= m_gate && (m_pend || f)) begin
          m_ph = 3; m_pend = 0; m_end = m_cyc + CONV; m_held = vin_bits; m_start = m_cyc;
        end else begin
          if (f) m_pend = 1;
          if (m_ph == 1 && m_cyc >= m_gate) m_ph = 2;
        end
      end
      m_prev = conv_start;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R7 powered vs model", powered, int'(m_ph != 0));
      chk("R3 R4 R8 R9 busy vs model", busy, int'(m_ph == 3));
      chk("R6 result_valid vs model", result_valid, int'(m_valid));
      if (m_valid) chk("R6 result vs model", result, m_res);
      if (m_ph == 3 && m_cyc == m_start) chk("R5 first trial code", trial_code, 8'h80);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Starts from conv_start high with the window open. Returns the busy length.
  task automatic do_conv(input logic [7:0] v, input bit stay, output int len);
    vin_bits   = v;
    conv_start = 1'b0;
    len = 0;
    tick(1);
    while (busy && len < 1000) begin
      len++;
      if (len == 3 && stay) conv_start = 1'b1;
      tick(1);
    end
  endtask

  initial begin
    int len, lat;
    tick(3);
    chk("R1 powered in reset", powered, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 valid in reset", result_valid, 0);
    chk("R1 result in reset", result, 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 asleep without edge", powered, 0);

    // Automatic power-down conversion, mid-scale code
    conv_start = 1'b1;
    tick(1);
    chk("R2 powered after rise", powered, 1);
    tick(PWRUP_CYC + 3);
    do_conv(8'hA5, 1'b0, len);
    chk("R3 busy length", len, CONV);
    chk("R6 strobe at end", result_valid, 1);
    chk("R6 code A5", result, 8'hA5);
    chk("R7 sleeps when low", powered, 0);

    // Early fall during power-up, zero input
    vin_bits = 8'h00;
    conv_start = 1'b1;
    lat = 0;
    do begin
      tick(1);
      lat++;
      if (lat == 2) conv_start = 1'b0;
    end while (!busy && lat < 100);
    chk("R4 auto start latency", lat, PWRUP_CYC + 1);
    while (busy) tick(1);
    chk("R6 code 00", result, 8'h00);
    chk("R7 sleeps after auto start", powered, 0);

    // Edges during conversion ignored, full-scale, stays powered
    conv_start = 1'b1;
    tick(PWRUP_CYC + 2);
    vin_bits = 8'hFF;
    conv_start = 1'b0;
    tick(1);
    len = 0;
    while (busy && len < 1000) begin
      len++;
      if (len == 4) conv_start = 1'b1;
      if (len == 6) conv_start = 1'b0;
      if (len == 8) conv_start = 1'b1;
      tick(1);
    end
    chk("R9 length unchanged by edges", len, CONV);
    chk("R6 code FF", result, 8'hFF);
    chk("R7 stays powered when high", powered, 1);
    tick(ACQ_CYC + 3);
    chk("R9 no extra conversion", busy, 0);

    // Back-to-back in high-speed mode: fall inside acquisition is held
    do_conv(8'h5A, 1'b1, len);
    chk("R6 code 5A", result, 8'h5A);
    vin_bits = 8'h80;
    conv_start = 1'b0;
    lat = 0;
    do begin tick(1); lat++; end while (!busy && lat < 50);
    chk("R8 held start latency", lat, ACQ_CYC);
    len = 0;
    while (busy && len < 1000) begin
      len++;
      if (len == 3) conv_start = 1'b1;
      tick(1);
    end
    chk("R6 code 80", result, 8'h80);
    chk("R7 still powered", powered, 1);

    // Boundary codes
    tick(ACQ_CYC + 1);
    do_conv(8'h7F, 1'b0, len);
    chk("R6 code 7F", result, 8'h7F);
    chk("R7 down after 7F", powered, 0);
    conv_start = 1'b1;
    tick(PWRUP_CYC + 1);
    do_conv(8'h01, 1'b1, len);
    chk("R6 code 01", result, 8'h01);
    chk("R3 busy length again", len, CONV);
    tick(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule